// File: doc/BRIEF.md
# Tag-Steered Processing Element for a Reconfigurable Array

This block is one processing element of a coarse-grained reconfigurable array. It runs a statically scheduled loop body, and its local control memory holds several instruction groups called shards. A shard is one contiguous run of instruction words. The shards belong to mutually exclusive paths of a branch, so they share the same time slots. A small table maps each 2-bit branch tag value to the base address of one shard.

In every cycle of a run, the operands that arrive from the four neighbour ports carry a tag. The tag selects the shard, and a time-step counter selects the word inside that shard. The element executes one small ALU operation and registers the result. It emits the result with a new tag, so that downstream elements can pick their own shard in turn.

Configuration happens while the global run signal is low. Control-memory words and base-table entries are written through simple write ports. The loop length is given on its own input.

Top module: `tag_pe`

## Requirements
- R1: After reset, out_vld, out_data and out_tag are 0, the time step is 0 and the local register is 0.
- R2: The fetch address is base[tag] + time step, taken modulo the control-memory depth. The tag comes from the valid input port of highest priority. Ports are indexed N=0, E=1, S=2, W=3, and a lower index wins.
- R3: The instruction word has these fields from bit 0 upward: op[2:0], srcA[5:3], srcB[8:6], dst_en[9], tag[11:10]. Opcodes: 0 add, 1 sub (A-B), 2 and, 3 or, 4 xor, 5 unsigned less-than (result 1 or 0), 6 and 7 pass A.
- R4: Operand source codes: 0 N, 1 E, 2 S, 3 W, 4 local register, 5 to 7 zero. Port p data sits at in_data[p*DW +: DW], and its tag sits at in_tag[p*2 +: 2].
- R5: A compare emits out_tag = {tag field bit 1, comparison result}.
- R6: Every other opcode emits out_tag equal to the instruction's tag field.
- R7: With run high and at least one in_vld bit set, the result and tag appear on out_data/out_tag, with out_vld high, one clock later.
- R8: With no valid input, or with run low, out_vld is low in the next cycle and the local register keeps its value.
- R9: An issued instruction with dst_en set writes its result into the local register.
- R10: The time step advances once per run cycle, returns to 0 after loop_len-1, and is held at 0 while run is low.
- R11: Writes to the control memory and to the base table take effect only while run is low. While run is high they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Global enable; configuration is allowed only while low |
| loop_len | input | TS_W | Number of time steps in the loop body |
| cfg_we | input | 1 | Control-memory write strobe |
| cfg_addr | input | CM_AW | Control-memory write address |
| cfg_data | input | IW | Instruction word to write |
| base_we | input | 1 | Base-table write strobe |
| base_tag | input | TAG_W | Tag value whose shard base is written |
| base_addr | input | CM_AW | Shard base address |
| in_vld | input | 4 | Per-port operand valid (N,E,S,W) |
| in_tag | input | 4*TAG_W | Per-port branch tags |
| in_data | input | 4*DW | Per-port operand data |
| out_vld | output | 1 | Result valid |
| out_tag | output | TAG_W | Tag emitted with the result |
| out_data | output | DW | Result data |

## Verification
The assertions check the following on every cycle. An issue cycle is followed by a valid output, and an idle cycle by an invalid one. The local register holds still whenever nothing issues. The time step returns to zero at the loop boundary and stays at zero while stopped. Each compare result agrees with the low bit of its emitted tag. The bench scenarios are the only place where several behaviours can be seen, because these depend on the configured program: correct shard selection from the tag, port priority when several ports are valid, the ALU arithmetic, and the rejection of writes made during a run.

// File: rtl/tag_pe_pkg.sv
package tag_pe_pkg;
  localparam int PORTS   = 4;
  localparam int OP_LSB  = 0;
  localparam int SA_LSB  = 3;
  localparam int SB_LSB  = 6;
  localparam int DEN_BIT = 9;
  localparam int TAG_LSB = 10;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
    OP_XOR = 3'd4, OP_LT  = 3'd5, OP_PASS = 3'd6, OP_PASS2 = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    SRC_N = 3'd0, SRC_E = 3'd1, SRC_S = 3'd2, SRC_W = 3'd3,
    SRC_REG = 3'd4, SRC_Z5 = 3'd5, SRC_Z6 = 3'd6, SRC_Z7 = 3'd7
  } src_e;
endpackage

// File: rtl/tag_pe_tstep.sv
module tag_pe_tstep #(
  parameter int TS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [TS_W-1:0] loop_len,
  output logic [TS_W-1:0] ts
);
  logic [TS_W:0] ts_inc;
  logic          at_end;

  assign ts_inc = {1'b0, ts} + 1'b1;
  assign at_end = ts_inc >= {1'b0, loop_len};

  always_ff @(posedge clk) begin
    if (!rst_n || !run) ts <= '0;
    else if (at_end)    ts <= '0;
    else                ts <= ts_inc[TS_W-1:0];
  end
endmodule

// File: rtl/tag_pe_cmem.sv
module tag_pe_cmem #(
  parameter int IW    = 12,
  parameter int CM_AW = 4,
  parameter int TAG_W = 2,
  parameter int TS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_we,
  input  logic [CM_AW-1:0] cfg_addr,
  input  logic [IW-1:0]    cfg_data,
  input  logic             base_we,
  input  logic [TAG_W-1:0] base_tag,
  input  logic [CM_AW-1:0] base_addr,
  input  logic [TAG_W-1:0] sel_tag,
  input  logic [TS_W-1:0]  ts,
  output logic [CM_AW-1:0] fetch_addr,
  output logic [IW-1:0]    instr
);
  localparam int DEPTH  = 1 << CM_AW;
  localparam int NSHARD = 1 << TAG_W;

  logic [IW-1:0]    mem  [DEPTH];
  logic [CM_AW-1:0] base [NSHARD];
  logic             cfg_ok;

  assign cfg_ok = !run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (cfg_ok && cfg_we) begin
      mem[cfg_addr] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSHARD; i++) base[i] <= '0;
    end else if (cfg_ok && base_we) begin
      base[base_tag] <= base_addr;
    end
  end

  assign fetch_addr = base[sel_tag] + CM_AW'(ts);
  assign instr      = mem[fetch_addr];
endmodule

// File: rtl/tag_pe_exec.sv
module tag_pe_exec
  import tag_pe_pkg::*;
#(
  parameter int DW    = 16,
  parameter int TAG_W = 2,
  parameter int IW    = 12
) (
  input  logic [IW-1:0]       instr,
  input  logic [PORTS*DW-1:0] in_data,
  input  logic [DW-1:0]       lreg,
  output logic [DW-1:0]       result,
  output logic [TAG_W-1:0]    tag_nxt,
  output logic                is_cmp,
  output logic                dst_en
);
  op_e               op;
  src_e              sa, sb;
  logic [TAG_W-1:0]  tag_fld;
  logic [DW-1:0]     opa, opb;

  function automatic logic [DW-1:0] pick(src_e s, logic [PORTS*DW-1:0] d, logic [DW-1:0] r);
    case (s)
      SRC_N:   return d[0*DW +: DW];
      SRC_E:   return d[1*DW +: DW];
      SRC_S:   return d[2*DW +: DW];
      SRC_W:   return d[3*DW +: DW];
      SRC_REG: return r;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] alu(op_e o, logic [DW-1:0] a, logic [DW-1:0] b);
    case (o)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_LT:   return (a < b) ? DW'(1) : '0;
      default: return a;
    endcase
  endfunction

  assign op      = op_e'(instr[OP_LSB +: 3]);
  assign sa      = src_e'(instr[SA_LSB +: 3]);
  assign sb      = src_e'(instr[SB_LSB +: 3]);
  assign dst_en  = instr[DEN_BIT];
  assign tag_fld = instr[TAG_LSB +: TAG_W];

  assign opa    = pick(sa, in_data, lreg);
  assign opb    = pick(sb, in_data, lreg);
  assign result = alu(op, opa, opb);
  assign is_cmp = (op == OP_LT);

  generate
    if (TAG_W > 1) begin : g_wide
      assign tag_nxt = is_cmp ? {tag_fld[TAG_W-1:1], result[0]} : tag_fld;
    end else begin : g_narrow
      assign tag_nxt = is_cmp ? result[0] : tag_fld;
    end
  endgenerate
endmodule

// File: rtl/tag_pe.sv
module tag_pe
  import tag_pe_pkg::*;
#(
  parameter int DW    = 16,
  parameter int TAG_W = 2,
  parameter int CM_AW = 4,
  parameter int TS_W  = 4,
  localparam int IW   = TAG_LSB + TAG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [TS_W-1:0]       loop_len,
  input  logic                  cfg_we,
  input  logic [CM_AW-1:0]      cfg_addr,
  input  logic [IW-1:0]         cfg_data,
  input  logic                  base_we,
  input  logic [TAG_W-1:0]      base_tag,
  input  logic [CM_AW-1:0]      base_addr,
  input  logic [PORTS-1:0]      in_vld,
  input  logic [PORTS*TAG_W-1:0] in_tag,
  input  logic [PORTS*DW-1:0]   in_data,
  output logic                  out_vld,
  output logic [TAG_W-1:0]      out_tag,
  output logic [DW-1:0]         out_data
);
  logic [TS_W-1:0]  ts;
  logic [TAG_W-1:0] sel_tag;
  logic [CM_AW-1:0] fetch_addr;
  logic [IW-1:0]    instr;
  logic [DW-1:0]    lreg;
  logic [DW-1:0]    result;
  logic [TAG_W-1:0] tag_nxt;
  logic             is_cmp;
  logic             dst_en;
  logic             issue;

  assign issue = run && (|in_vld);

  always_comb begin
    sel_tag = '0;
    for (int p = PORTS-1; p >= 0; p--) begin
      if (in_vld[p]) sel_tag = in_tag[p*TAG_W +: TAG_W];
    end
  end

  tag_pe_tstep #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .run(run), .loop_len(loop_len), .ts(ts)
  );

  tag_pe_cmem #(.IW(IW), .CM_AW(CM_AW), .TAG_W(TAG_W), .TS_W(TS_W)) u_cm (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .base_we(base_we), .base_tag(base_tag), .base_addr(base_addr),
    .sel_tag(sel_tag), .ts(ts), .fetch_addr(fetch_addr), .instr(instr)
  );

  tag_pe_exec #(.DW(DW), .TAG_W(TAG_W), .IW(IW)) u_ex (
    .instr(instr), .in_data(in_data), .lreg(lreg),
    .result(result), .tag_nxt(tag_nxt), .is_cmp(is_cmp), .dst_en(dst_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_tag  <= '0;
      out_data <= '0;
      lreg     <= '0;
    end else begin
      out_vld <= issue;
      if (issue) begin
        out_tag  <= tag_nxt;
        out_data <= result;
        if (dst_en) lreg <= result;
      end
    end
  end
endmodule

// File: rtl/tag_pe_chk.sv
module tag_pe_chk #(
  parameter int DW    = 16,
  parameter int TAG_W = 2,
  parameter int TS_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             issue,
  input logic             is_cmp,
  input logic [TS_W-1:0]  ts,
  input logic [TS_W-1:0]  loop_len,
  input logic [DW-1:0]    lreg,
  input logic             out_vld,
  input logic [TAG_W-1:0] out_tag,
  input logic [DW-1:0]    out_data
);
  // R7
  issue_gives_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> out_vld);

  // R8
  idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !out_vld);

  // R8
  idle_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(lreg));

  // R10
  ts_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (({1'b0, ts} + 1'b1) >= {1'b0, loop_len})) |=> (ts == '0));

  // R10
  ts_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ts == '0));

  // R5
  cmp_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && is_cmp) |=> (out_tag[0] == out_data[0]) && (out_data[DW-1:1] == '0));
endmodule

bind tag_pe tag_pe_chk #(.DW(DW), .TAG_W(TAG_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .issue(issue), .is_cmp(is_cmp),
  .ts(ts), .loop_len(loop_len), .lreg(lreg),
  .out_vld(out_vld), .out_tag(out_tag), .out_data(out_data)
);

// File: tb/sim_tag_pe.sv
module sim_tag_pe;
  typedef struct packed {
    logic [3:0]  vld;
    logic [7:0]  tags;
    logic [63:0] data;
    logic        ev;
    logic [15:0] ed;
    logic [1:0]  et;
  } vec_t;

  // shard bases: tag0->0, tag1->4, tag2->8, tag3->12; loop_len 2
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'b0011, 8'h00, 64'h0000_0000_0007_0005, 1'b1, 16'h000C, 2'd0}, // R3 add, R9
    '{4'b0001, 8'h00, 64'h0000_0000_0000_0000, 1'b1, 16'h000C, 2'd2}, // R4 reg, R6
    '{4'b0011, 8'h55, 64'h0000_0000_000A_0003, 1'b1, 16'hFFF9, 2'd1}, // R3 sub
    '{4'b0001, 8'h55, 64'h0000_0000_0000_00F0, 1'b1, 16'h00FC, 2'd1}, // R3 xor, R9
    '{4'b0011, 8'hAA, 64'h0000_0000_0009_0004, 1'b1, 16'h0001, 2'd3}, // R5 true
    '{4'b0101, 8'hAA, 64'h0000_3C3C_0000_0FF0, 1'b1, 16'h0C30, 2'd3}, // R3 and
    '{4'b0011, 8'hAA, 64'h0000_0000_0004_0009, 1'b1, 16'h0000, 2'd2}, // R5 false
    '{4'b0100, 8'hFF, 64'h0000_1234_0000_0000, 1'b1, 16'h1234, 2'd0}, // R2 shard3
    '{4'b0000, 8'h00, 64'h0000_0000_0000_0000, 1'b0, 16'h0000, 2'd0}, // R8 idle
    '{4'b0001, 8'h00, 64'h0000_0000_0000_0000, 1'b1, 16'h1234, 2'd2}, // R8 reg kept
    '{4'b1010, 8'h0C, 64'h000A_0000_000F_0000, 1'b1, 16'h000F, 2'd3}, // R2 priority, R3 or
    '{4'b1111, 8'h55, 64'h0000_0000_0000_1200, 1'b1, 16'h0034, 2'd1}  // R3 xor reg
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [3:0]  loop_len = 4'd2;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [11:0] cfg_data = '0;
  logic        base_we = 1'b0;
  logic [1:0]  base_tag = '0;
  logic [3:0]  base_addr = '0;
  logic [3:0]  in_vld = '0;
  logic [7:0]  in_tag = '0;
  logic [63:0] in_data = '0;
  logic        out_vld;
  logic [1:0]  out_tag;
  logic [15:0] out_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tag_pe u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .loop_len(loop_len),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .base_we(base_we), .base_tag(base_tag), .base_addr(base_addr),
    .in_vld(in_vld), .in_tag(in_tag), .in_data(in_data),
    .out_vld(out_vld), .out_tag(out_tag), .out_data(out_data)
  );

  function automatic logic [11:0] mk(logic [2:0] op, logic [2:0] a, logic [2:0] b,
                                     logic den, logic [1:0] t);
    return {t, den, b, a, op};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_cm(logic [3:0] a, logic [11:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_base(logic [1:0] t, logic [3:0] a);
    base_we = 1'b1; base_tag = t; base_addr = a;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  // drive at negedge, result registered at posedge, sample next negedge
  task automatic step(logic [3:0] v, logic [7:0] t, logic [63:0] d);
    in_vld = v; in_tag = t; in_data = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_vld", 32'(out_vld), 0);
    chk("R1 out_data", 32'(out_data), 0);
    chk("R1 out_tag", 32'(out_tag), 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr_base(2'd0, 4'd0);
    wr_base(2'd1, 4'd4);
    wr_base(2'd2, 4'd8);
    wr_base(2'd3, 4'd12);
    wr_cm(4'd0,  mk(3'd0, 3'd0, 3'd1, 1'b1, 2'd0)); // add N,E -> reg
    wr_cm(4'd1,  mk(3'd6, 3'd4, 3'd0, 1'b0, 2'd2)); // pass reg
    wr_cm(4'd4,  mk(3'd1, 3'd0, 3'd1, 1'b0, 2'd1)); // sub N,E
    wr_cm(4'd5,  mk(3'd4, 3'd0, 3'd4, 1'b1, 2'd1)); // xor N,reg -> reg
    wr_cm(4'd8,  mk(3'd5, 3'd0, 3'd1, 1'b0, 2'd2)); // lt N,E
    wr_cm(4'd9,  mk(3'd2, 3'd0, 3'd2, 1'b0, 2'd3)); // and N,S
    wr_cm(4'd12, mk(3'd3, 3'd3, 3'd1, 1'b0, 2'd3)); // or W,E
    wr_cm(4'd13, mk(3'd6, 3'd2, 3'd0, 1'b1, 2'd0)); // pass S -> reg

    // R8: valid input while stopped produces nothing
    step(4'b0011, 8'h00, 64'h0000_0000_0007_0005);
    chk("R8 run low", 32'(out_vld), 0);

    run = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].vld, VEC[i].tags, VEC[i].data);
      chk($sformatf("R7 vld v%0d", i), 32'(out_vld), 32'(VEC[i].ev));
      if (VEC[i].ev) begin
        chk($sformatf("R3 data v%0d", i), 32'(out_data), 32'(VEC[i].ed));
        chk($sformatf("R6 tag v%0d", i), 32'(out_tag), 32'(VEC[i].et));
      end
    end

    // R11: write during run ignored (cm[0] stays add)
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_data = mk(3'd6, 3'd2, 3'd0, 1'b0, 2'd1);
    step(4'b0000, 8'h00, 64'h0);
    cfg_we = 1'b0;
    chk("R8 idle", 32'(out_vld), 0);
    step(4'b0000, 8'h00, 64'h0);
    step(4'b0011, 8'h00, 64'h0000_0064_0002_0001);
    chk("R11 cm kept data", 32'(out_data), 32'h3);
    chk("R11 cm kept tag", 32'(out_tag), 0);

    // reconfigure while stopped, loop length 3
    run = 1'b0;
    step(4'b0000, 8'h00, 64'h0);
    wr_cm(4'd0, mk(3'd6, 3'd2, 3'd0, 1'b0, 2'd1)); // pass S
    wr_cm(4'd2, mk(3'd6, 3'd0, 3'd0, 1'b0, 2'd3)); // pass N
    loop_len = 4'd3;
    run = 1'b1;
    step(4'b0001, 8'h00, 64'h0000_0064_0000_0037);
    chk("R11 cm written data", 32'(out_data), 32'h64);
    chk("R11 cm written tag", 32'(out_tag), 1);
    step(4'b0001, 8'h00, 64'h0000_0064_0000_0037);
    chk("R10 ts1 data", 32'(out_data), 32'h3);
    chk("R10 ts1 tag", 32'(out_tag), 2);
    step(4'b0001, 8'h00, 64'h0000_0064_0000_0037);
    chk("R10 ts2 data", 32'(out_data), 32'h37);
    chk("R10 ts2 tag", 32'(out_tag), 3);
    step(4'b0001, 8'h00, 64'h0000_0064_0000_0037);
    chk("R10 wrap data", 32'(out_data), 32'h64);
    chk("R10 wrap tag", 32'(out_tag), 1);

    // R1: reset mid-run
    rst_n = 1'b0;
    step(4'b0001, 8'h00, 64'h0000_0064_0000_0037);
    chk("R1 reset vld", 32'(out_vld), 0);
    chk("R1 reset data", 32'(out_data), 0);
    chk("R1 reset tag", 32'(out_tag), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule